// File: doc/BRIEF.md
# Three-Operand Carry-Save Multiplier

This block forms the unsigned product of three N-bit operands in a single cell and returns it on a 3N-bit result. The first two operands are multiplied into an array of AND terms. That array is compressed to a redundant pair of rows, a sum row and a carry row, and no carry-propagate addition is done at this point. Each bit of the third operand then gates both rows of that pair. The resulting second array is compressed with 4:2 compressor rows down to two rows, and one carry-propagate adder resolves them.

A parameter selects an alternative array in which every partial product is a three-input AND of one bit from each operand. That array goes through the same 4:2 compression and the same final adder. A second parameter places one register stage, with a synchronous active-low reset, on the result. When that stage is off, the path from operands to result is purely combinational.

Top module: `tri_mult`

## Requirements
- R1: `prod_o` equals the unsigned product `a_i * b_i * c_i`, exact in 3N bits, for every operand combination.
- R2: Any zero operand gives a zero result. All-ones operands give (2^N-1)^3, which is 3375 for N = 4, with no bit lost.
- R3: With `ARCH = ARCH_CSA` (value 0), the A×B terms are reduced to one sum row and one carry row. Their modular sum equals A×B, and no carry-propagate adder is used.
- R4: With `ARCH = ARCH_CSA`, the second array holds 2N rows. Row pair k is the sum row and the carry row ANDed with bit k of `c_i`, both shifted left by k.
- R5: Each 4:2 compression level preserves the total of its rows modulo 2^(3N). The pair left after the last level sums to the full three-operand product.
- R6: Exactly one carry-propagate addition forms `prod_o`, from the two final rows.
- R7: With `ARCH = ARCH_AND3` (value 1), the array consists of N×N rows of terms `a_i & b_j & c_k` at weight 2^(i+j+k), and the result is identical to R1.
- R8: With `REG_OUT = 1`, `prod_o` shows the product of the operands sampled at the previous rising clock edge. While `rst_n` is low at a rising edge, `prod_o` becomes 0.
- R9: With `REG_OUT = 0`, `prod_o` follows the operands without a clock, and `rst_n` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Synchronous active-low reset of the result register |
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| c_i | input | N | Third unsigned operand |
| prod_o | output | 3N | Unsigned product of the three operands |

## Verification
The bench runs two instances side by side: the carry-save array registered, and the three-input AND array combinational. It first applies directed corners: zeros in each position, all ones, single bits and powers of two. These separate weight errors in the shifts from errors in the dropped top carries. It then sweeps all 4096 operand triples, which exercises every row gating pattern of the third operand, and adds seeded random triples. On the registered instance, each result is checked both before and after the clock edge, so a missing or extra stage is caught. A mid-run reset shows that the registered result is cleared while the combinational result is unaffected.

// File: rtl/tri_mult_pkg.sv
`timescale 1ns/1ps
package tri_mult_pkg;

    typedef enum logic [0:0] {
        ARCH_CSA  = 1'b0,
        ARCH_AND3 = 1'b1
    } arch_e;

    // rows left after one compression level: groups of four become two,
    // a remainder of three goes through a compressor with one zero row
    function automatic int next_rows(input int r);
        if (r <= 2) return r;
        return 2 * (r / 4) + (((r % 4) == 3) ? 2 : (r % 4));
    endfunction

    function automatic int rows_at(input int r, input int lvl);
        int cur;
        cur = r;
        for (int i = 0; i < lvl; i++) cur = next_rows(cur);
        return cur;
    endfunction

    function automatic int num_levels(input int r);
        int cur;
        int n;
        cur = r;
        n   = 0;
        while (cur > 2) begin
            cur = next_rows(cur);
            n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/tri_mult_cmp42_row.sv
`timescale 1ns/1ps
// One row of 4:2 compressors. Each column is two chained full adders; the
// first adder's carry runs sideways into the next column. Carries leaving
// the top column carry weight 2^W and are dropped (modulo arithmetic).
module tri_mult_cmp42_row #(
    parameter int W = 12
) (
    input  logic [W-1:0] x0_i,
    input  logic [W-1:0] x1_i,
    input  logic [W-1:0] x2_i,
    input  logic [W-1:0] x3_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] car_o
);
    logic [W-1:0] lat;

    assign lat[0]   = 1'b0;
    assign car_o[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_col
        logic s1;
        assign s1       = x0_i[i] ^ x1_i[i] ^ x2_i[i];
        assign sum_o[i] = s1 ^ x3_i[i] ^ lat[i];
        if (i < W - 1) begin : g_fwd
            assign lat[i+1]   = (x0_i[i] & x1_i[i]) | (x0_i[i] & x2_i[i]) | (x1_i[i] & x2_i[i]);
            assign car_o[i+1] = (s1 & x3_i[i]) | (s1 & lat[i]) | (x3_i[i] & lat[i]);
        end
    end

endmodule

// File: rtl/tri_mult_reduce.sv
`timescale 1ns/1ps
// Compresses ROWS rows of width W to one sum row and one carry row using
// levels of 4:2 compressor rows. No carry-propagate addition inside.
module tri_mult_reduce
    import tri_mult_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int W    = 12
) (
    input  logic [ROWS-1:0][W-1:0] rows_i,
    output logic [W-1:0]           sum_o,
    output logic [W-1:0]           car_o
);
    localparam int NLEV = num_levels(ROWS);

    if (ROWS == 1) begin : g_one
        assign sum_o = rows_i[0];
        assign car_o = '0;
    end else if (ROWS == 2) begin : g_two
        assign sum_o = rows_i[0];
        assign car_o = rows_i[1];
    end else begin : g_tree
        for (genvar L = 0; L < NLEV; L++) begin : lvl
            localparam int R   = rows_at(ROWS, L);
            localparam int RN  = rows_at(ROWS, L + 1);
            localparam int G   = R / 4;
            localparam int REM = R % 4;

            logic [R-1:0][W-1:0]  cur;
            logic [RN-1:0][W-1:0] nxt;

            if (L == 0) begin : g_first
                assign cur = rows_i;
            end else begin : g_rest
                assign cur = lvl[L-1].nxt;
            end

            for (genvar g = 0; g < G; g++) begin : g_grp
                tri_mult_cmp42_row #(.W(W)) u_cmp (
                    .x0_i (cur[4*g]),
                    .x1_i (cur[4*g+1]),
                    .x2_i (cur[4*g+2]),
                    .x3_i (cur[4*g+3]),
                    .sum_o(nxt[2*g]),
                    .car_o(nxt[2*g+1])
                );
            end

            if (REM == 3) begin : g_rem3
                tri_mult_cmp42_row #(.W(W)) u_cmp (
                    .x0_i (cur[4*G]),
                    .x1_i (cur[4*G+1]),
                    .x2_i (cur[4*G+2]),
                    .x3_i ({W{1'b0}}),
                    .sum_o(nxt[2*G]),
                    .car_o(nxt[2*G+1])
                );
            end else begin : g_pass
                for (genvar r = 0; r < REM; r++) begin : g_row
                    assign nxt[2*G+r] = cur[4*G+r];
                end
            end
        end

        assign sum_o = lvl[NLEV-1].nxt[0];
        assign car_o = lvl[NLEV-1].nxt[1];
    end

endmodule

// File: rtl/tri_mult.sv
`timescale 1ns/1ps
module tri_mult
    import tri_mult_pkg::*;
#(
    parameter int    N       = 4,
    parameter arch_e ARCH    = ARCH_CSA,
    parameter bit    REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    input  logic [N-1:0]   c_i,
    output logic [3*N-1:0] prod_o
);
    localparam int PW = 3 * N;

    typedef struct packed {
        logic [PW-1:0] prod;
    } state_t;

    logic [PW-1:0] a_w;
    logic [PW-1:0] fin_s;
    logic [PW-1:0] fin_c;
    state_t        state_d;

    assign a_w = PW'(a_i);

    if (ARCH == ARCH_CSA) begin : g_csa
        logic [N-1:0][PW-1:0]   pp1;
        logic [2*N-1:0][PW-1:0] pp2;
        logic [PW-1:0]          s1;
        logic [PW-1:0]          c1;

        // first array: a & b_j at weight 2^j
        for (genvar j = 0; j < N; j++) begin : g_pp1
            assign pp1[j] = ({PW{b_i[j]}} & a_w) << j;
        end

        tri_mult_reduce #(.ROWS(N), .W(PW)) u_red1 (
            .rows_i(pp1),
            .sum_o (s1),
            .car_o (c1)
        );

        // second array: both redundant rows gated by c_k at weight 2^k
        for (genvar k = 0; k < N; k++) begin : g_pp2
            assign pp2[2*k]   = ({PW{c_i[k]}} & s1) << k;
            assign pp2[2*k+1] = ({PW{c_i[k]}} & c1) << k;
        end

        tri_mult_reduce #(.ROWS(2*N), .W(PW)) u_red2 (
            .rows_i(pp2),
            .sum_o (fin_s),
            .car_o (fin_c)
        );

        // R3: the redundant pair represents A*B before any carry resolution
        assert_pair_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (s1 + c1) == (a_w * PW'(b_i)));

        // R5: compressing the gated array keeps (s1+c1)*C
        assert_two_rows_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (fin_s + fin_c) == ((s1 + c1) * PW'(c_i)));
    end else begin : g_and3
        logic [N*N-1:0][PW-1:0] pp;

        // every row: a & b_j & c_k at weight 2^(j+k)
        for (genvar j = 0; j < N; j++) begin : g_j
            for (genvar k = 0; k < N; k++) begin : g_k
                assign pp[j*N+k] = ({PW{b_i[j] & c_i[k]}} & a_w) << (j + k);
            end
        end

        tri_mult_reduce #(.ROWS(N*N), .W(PW)) u_red (
            .rows_i(pp),
            .sum_o (fin_s),
            .car_o (fin_c)
        );

        // R5, R7: the two rows left from the AND3 array carry the product
        assert_two_rows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (fin_s + fin_c) == (a_w * PW'(b_i) * PW'(c_i)));
    end

    // R6: the only carry-propagate addition in the block
    always_comb begin
        state_d      = '0;
        state_d.prod = fin_s + fin_c;
    end

    if (REG_OUT) begin : g_reg
        state_t state_q;

        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= '0;
            else        state_q <= state_d;
        end

        assign prod_o = state_q.prod;

        // R8: register cleared by reset
        assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (prod_o == '0));

        // R1, R8: product of the previous cycle's operands
        assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (prod_o == (PW'($past(a_i)) * PW'($past(b_i)) * PW'($past(c_i)))));
    end else begin : g_comb
        assign prod_o = state_d.prod;

        // R1, R9: combinational product
        assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            prod_o == (a_w * PW'(b_i) * PW'(c_i)));
    end

endmodule

// File: tb/sim_tri_mult.sv
`timescale 1ns/1ps
module sim_tri_mult;
    import tri_mult_pkg::*;

    localparam int N  = 4;
    localparam int PW = 3 * N;
    localparam int LIM = (1 << N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  a, b, c;
    logic [PW-1:0] p0, p1;
    logic [PW-1:0] held;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tri_mult #(.N(N), .ARCH(ARCH_CSA), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .c_i(c), .prod_o(p0)
    );

    tri_mult #(.N(N), .ARCH(ARCH_AND3), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .c_i(c), .prod_o(p1)
    );

    function automatic logic [PW-1:0] ref_prod(input int x, input int y, input int z);
        int full;
        full = x * y * z;
        return PW'(full);
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d c=%0d)", req, act, exp, a, b, c);
        end
    endtask

    // drive a triple, check both instances around the next rising edge
    task automatic apply(input int x, input int y, input int z);
        logic [PW-1:0] e;
        @(negedge clk);
        a = N'(x); b = N'(y); c = N'(z);
        e = ref_prod(x, y, z);
        #1;
        check("R7 R9 and3 comb", p1, e);
        check("R8 holds before edge", p0, held);
        @(posedge clk);
        #1;
        check("R1 R3 R4 R5 R6 carry-save", p0, e);
        held = e;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        a = '1; b = '1; c = '1;
        repeat (2) @(posedge clk);
        #1;
        check("R8 reset state", p0, '0);
        check("R9 reset ignored", p1, ref_prod(LIM-1, LIM-1, LIM-1));

        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        held = ref_prod(LIM-1, LIM-1, LIM-1);
        check("R8 first capture", p0, held);

        // directed corners (R2)
        apply(0, LIM-1, LIM-1);
        check("R2 zero a", p0, '0);
        apply(LIM-1, 0, LIM-1);
        check("R2 zero b", p0, '0);
        apply(LIM-1, LIM-1, 0);
        check("R2 zero c", p0, '0);
        apply(LIM-1, LIM-1, LIM-1);
        check("R2 all ones", p0, PW'(3375));
        apply(1, 1, 1);
        apply(LIM/2, LIM/2, LIM/2);
        apply(1, LIM-1, LIM/2);
        apply(LIM-1, 1, 1);

        // mid-run reset: registered path clears, combinational does not (R8 R9)
        @(negedge clk);
        a = N'(13); b = N'(11); c = N'(7);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R8 sync reset", p0, '0);
        check("R9 reset no effect", p1, ref_prod(13, 11, 7));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        held = ref_prod(13, 11, 7);
        check("R8 after release", p0, held);

        // exhaustive sweep
        for (int x = 0; x < LIM; x++)
            for (int y = 0; y < LIM; y++)
                for (int z = 0; z < LIM; z++)
                    apply(x, y, z);

        // seeded random triples
        for (int i = 0; i < 400; i++)
            apply(int'($urandom % LIM), int'($urandom % LIM), int'($urandom % LIM));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule